// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analogue-to-digital converter. After a start strobe it puts a trial code on a bus that feeds an external DAC. It reads back a single comparator decision and settles one result bit on every clock, beginning with the most significant bit. An N-bit conversion therefore always takes N clocks. The DAC, the comparator and any sample-and-hold stay outside the block.

Each bit is reported in two ways as it is decided. It goes out on a serial line, MSB first, with a valid qualifier. It also builds up in the trial register. When the least significant bit has been decided, the finished word is copied into a parallel result register and a done flag pulses for one clock. The result register keeps that word until the next conversion completes.

Top module: `sar_ctrl`

## Requirements
- R1: When `start` is high in a cycle where `busy` is low, the next cycle has `busy` high and `dac_code` holding only its top bit (for N=4, 4'b1000).
- R2: On each busy cycle the bit under trial takes the value of `cmp`. A 1 (input strictly above the DAC level) keeps it at 1 and a 0 clears it. An input equal to the DAC level therefore clears the bit.
- R3: On the same edge where a bit that is not the LSB is decided, the next lower bit of `dac_code` is set to 1. Bits that were decided earlier do not change.
- R4: `busy` stays high for exactly N consecutive cycles per conversion. `done` is high in the first cycle after them.
- R5: With N=4, an input of 5.2 and one unit per code, `dac_code` goes through 1000, 0100, 0110 and 0101, and `result` ends at 0101.
- R6: In the cycle after each busy cycle, `ser_vld` is high and `ser_bit` carries that cycle's decision. Read in order, the N serial bits give `result` MSB first. `ser_vld` is low at all other times.
- R7: `done` is high for exactly one cycle, and in that cycle `result` holds the finished word. `result` changes at no other time.
- R8: A `start` seen while `busy` is high has no effect on the running conversion, its length or its result, and does not begin a new one.
- R9: A synchronous active-high `rst` returns the block to idle on the next edge. `dac_code` and `result` are zero, and `busy`, `done` and `ser_vld` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, sampled while idle |
| cmp | input | 1 | Comparator decision: 1 when input exceeds DAC level |
| dac_code | output | N | Trial code driven to the DAC |
| result | output | N | Parallel result of the last completed conversion |
| ser_bit | output | 1 | Most recently decided bit |
| ser_vld | output | 1 | Qualifies `ser_bit` |
| done | output | 1 | One-cycle pulse at completion |
| busy | output | 1 | Conversion in progress |

## Verification
The assertions assume that `cmp` is a settled decision about the `dac_code` of the same cycle. In other words, they assume the external DAC and comparator settle within one clock. The bench meets this by deriving `cmp` combinationally from the current `dac_code` and an integer stand-in for the analogue level, given in tenths of a code step. Analogue values are changed only while the block is idle. `start` is driven between clock edges, and it is also raised on purpose during a conversion, to show that a request arriving then is ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } sar_phase_t;

    // Control strobes passed from the sequencer to the datapath
    typedef struct packed {
        logic load;    // begin a conversion: seed the trial code
        logic decide;  // resolve the bit under trial this cycle
        logic last;    // the bit under trial is the LSB
    } sar_ctl_t;

    // One serial beat
    typedef struct packed {
        logic vld;
        logic dat;
    } sar_beat_t;

    function automatic int sar_ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    output sar_ctl_t                      ctl,
    output logic [sar_ptr_width(N)-1:0]   ptr,
    output logic                          busy
);
    localparam int PW = sar_ptr_width(N);
    localparam logic [PW-1:0] TOP = PW'(N - 1);

    sar_phase_t    phase_q, phase_d;
    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        ctl.load   = (phase_q == PH_IDLE) && start;
        ctl.decide = (phase_q == PH_CONV);
        ctl.last   = (phase_q == PH_CONV) && (ptr_q == '0);
    end

    always_comb begin
        phase_d = phase_q;
        ptr_d   = ptr_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_CONV;
                    ptr_d   = TOP;
                end
            end
            PH_CONV: begin
                if (ptr_q == '0) begin
                    phase_d = PH_IDLE;
                end else begin
                    ptr_d = ptr_q - 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
        end else begin
            phase_q <= phase_d;
            ptr_q   <= ptr_d;
        end
    end

    assign ptr  = ptr_q;
    assign busy = (phase_q == PH_CONV);

endmodule

// File: rtl/sar_trial.sv
module sar_trial
    import sar_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  sar_ctl_t                      ctl,
    input  logic [sar_ptr_width(N)-1:0]   ptr,
    input  logic                          cmp,
    output logic [N-1:0]                  code,
    output logic [N-1:0]                  code_nx
);
    logic [N-1:0] code_q;

    // One slice per bit: seeded on load, decided when pointed at,
    // armed when the bit above it is being decided.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            code_nx[i] = code_q[i];
            if (ctl.load) begin
                code_nx[i] = (i == N - 1);
            end else if (ctl.decide) begin
                if (int'(ptr) == i) begin
                    code_nx[i] = cmp;
                end else if (int'(ptr) == i + 1) begin
                    code_nx[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else begin
            code_q <= code_nx;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/sar_out.sv
module sar_out
    import sar_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  sar_ctl_t      ctl,
    input  logic          cmp,
    input  logic [N-1:0]  code_nx,
    output logic [N-1:0]  result,
    output sar_beat_t     beat,
    output logic          done
);
    logic [N-1:0] res_q;
    sar_beat_t    beat_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            beat_q <= '0;
            done_q <= 1'b0;
        end else begin
            beat_q.vld <= ctl.decide;
            beat_q.dat <= ctl.decide ? cmp : 1'b0;
            done_q     <= ctl.last;
            if (ctl.last) begin
                res_q <= code_nx;
            end
        end
    end

    assign result = res_q;
    assign beat   = beat_q;
    assign done   = done_q;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cmp,
    output logic [N-1:0]  dac_code,
    output logic [N-1:0]  result,
    output logic          ser_bit,
    output logic          ser_vld,
    output logic          done,
    output logic          busy
);
    localparam int PW = sar_ptr_width(N);

    sar_ctl_t      ctl;
    logic [PW-1:0] ptr;
    logic [N-1:0]  code_nx;
    sar_beat_t     beat;

    sar_seq #(.N(N)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .ptr   (ptr),
        .busy  (busy)
    );

    sar_trial #(.N(N)) u_trial (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .ptr     (ptr),
        .cmp     (cmp),
        .code    (dac_code),
        .code_nx (code_nx)
    );

    sar_out #(.N(N)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .cmp     (cmp),
        .code_nx (code_nx),
        .result  (result),
        .beat    (beat),
        .done    (done)
    );

    assign ser_bit = beat.dat;
    assign ser_vld = beat.vld;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int N = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          cmp,
    input logic [N-1:0]  dac_code,
    input logic [N-1:0]  result,
    input logic          ser_bit,
    input logic          ser_vld,
    input logic          done,
    input logic          busy
);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    // Busy cycles seen before the current cycle within one run
    int run_len;
    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= 0;
        else              run_len <= run_len + 1;
    end

    a_r1_seed_msb: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && dac_code == MSB_ONLY));

    a_r2_serial_is_decision: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ser_vld && ser_bit == $past(cmp)));

    a_r4_not_too_long: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < N));

    a_r4_done_after_n: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && run_len == N));

    a_r6_vld_only_after_busy: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !ser_vld);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(result)));

    a_r8_busy_start_no_reseed: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_len > 0) |=> (dac_code != MSB_ONLY || !busy || $past(dac_code) == MSB_ONLY || $past(cmp)));

    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ser_vld && dac_code == '0 && result == '0));

endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmp      (cmp),
    .dac_code (dac_code),
    .result   (result),
    .ser_bit  (ser_bit),
    .ser_vld  (ser_vld),
    .done     (done),
    .busy     (busy)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp;
    logic [N-1:0] dac_code, result;
    logic         ser_bit, ser_vld, done, busy;

    int analog = 0;   // analogue level in tenths of one code step
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign cmp = (analog > int'(dac_code) * 10);

    sar_ctrl #(.N(N)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmp(cmp),
        .dac_code(dac_code), .result(result),
        .ser_bit(ser_bit), .ser_vld(ser_vld), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference, compared each cycle ----------
    int m_busy = 0, m_code = 0, m_res = 0, m_done = 0, m_vld = 0, m_ser = 0, m_pos = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_code = 0; m_res = 0; m_done = 0; m_vld = 0; m_ser = 0; m_pos = 0;
        end else begin
            m_done = 0;
            m_vld  = 0;
            m_ser  = 0;
            if (m_busy != 0) begin
                int c;
                c = (analog > m_code * 10) ? 1 : 0;
                m_ser = c;
                m_vld = 1;
                if (c == 0) m_code = m_code & ~(1 << m_pos);
                if (m_pos > 0) begin
                    m_pos  = m_pos - 1;
                    m_code = m_code | (1 << m_pos);
                end else begin
                    m_busy = 0;
                    m_done = 1;
                    m_res  = m_code;
                end
            end else if (start) begin
                m_busy = 1;
                m_pos  = N - 1;
                m_code = 1 << (N - 1);
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check(int'(busy) == m_busy,         "R4 model busy",    int'(busy), m_busy);
            check(int'(dac_code) == m_code,     "R3 model code",    int'(dac_code), m_code);
            check(int'(result) == m_res,        "R7 model result",  int'(result), m_res);
            check(int'(done) == m_done,         "R7 model done",    int'(done), m_done);
            check(int'(ser_vld) == m_vld,       "R6 model ser_vld", int'(ser_vld), m_vld);
            check(int'(ser_bit) == m_ser,       "R6 model ser_bit", int'(ser_bit), m_ser);
        end
    end

    function automatic int expect_res(input int a);
        int v;
        if (a <= 0) return 0;
        v = (a - 1) / 10;
        return (v > (1 << N) - 1) ? (1 << N) - 1 : v;
    endfunction

    // One full conversion; optionally raises start during busy cycle 'poke'
    task automatic convert(input int a, input int poke, input bit show_seq);
        int codes[N];
        int ser_word;
        int exp;
        exp = expect_res(a);
        ser_word = 0;
        @(negedge clk);
        analog = a;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && dac_code == (1 << (N - 1)), "R1 seed", int'(dac_code), 1 << (N - 1));
        for (int i = 0; i < N; i++) begin
            codes[i] = int'(dac_code);
            check(busy == 1'b1, "R4 busy held", int'(busy), 1);
            start = (i == poke) ? 1'b1 : 1'b0;
            @(negedge clk);
            start = 1'b0;
            check(ser_vld == 1'b1, "R6 serial valid", int'(ser_vld), 1);
            ser_word = (ser_word << 1) | int'(ser_bit);
        end
        check(done == 1'b1 && busy == 1'b0, "R4 done after N", int'({done, busy}), 2);
        check(int'(result) == exp, "R2 result", int'(result), exp);
        check(ser_word == exp, "R6 serial word", ser_word, exp);
        if (show_seq) begin
            check(codes[0] == 8, "R5 trial 1", codes[0], 8);
            check(codes[1] == 4, "R5 trial 2", codes[1], 4);
            check(codes[2] == 6, "R5 trial 3", codes[2], 6);
            check(codes[3] == 5, "R5 trial 4", codes[3], 5);
        end
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", int'(done), 0);
        check(busy == 1'b0, "R8 no restart", int'(busy), 0);
        check(int'(result) == exp, "R7 result held", int'(result), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && dac_code == 0 && result == 0 && done == 0 && ser_vld == 0,
              "R9 reset state", int'(dac_code), 0);

        convert(52, -1, 1'b1);                 // R5 worked example
        convert(50, -1, 1'b0);                 // R2 equality clears bit -> 4
        convert(0, -1, 1'b0);                  // all zeros
        convert(200, -1, 1'b0);                // all ones
        convert(137, 1, 1'b0);                 // R8 start during busy
        convert(91, 0, 1'b0);                  // R8 start in first busy cycle

        // idle cycles leave the result alone
        repeat (3) @(negedge clk);
        check(int'(result) == 9, "R7 idle hold", int'(result), 9);

        // R3: code after first decision for 52: 0100
        @(negedge clk); analog = 52; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(int'(dac_code) == 4, "R3 next bit armed", int'(dac_code), 4);

        // R9: reset in mid-conversion
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && dac_code == 0 && result == 0 && ser_vld == 0,
              "R9 mid reset", int'(dac_code), 0);

        convert(73, -1, 1'b0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule